// File: doc/BRIEF.md
# SCSI Target Selection Decoder

This block sits on the target side of a SCSI bus and watches the selection phase while a wait-for-selection command is armed. Once armed, it looks for SEL asserted with BSY released and its own ID bit present on the data bus. After a programmable settle delay it samples the ID bits and ATN and sorts the selection into one of three kinds: a normal selection with two ID bits, a legacy selection that carries only the target's own bit, or an invalid selection with three or more bits.

Each kind sets its own set of sticky interrupt flags. A normal selection connects and moves on to message-out when ATN is present, or to command-out when it is not. A legacy selection also connects, so the controller can start message-out or command-out by hand. It sets the ID-error flag next to the selection flag, stays in no phase, and reports a missing ATN with a separate flag. An invalid selection sets only the ID-error flag and does not connect. Every decision ends the armed command.

Top module: `scsi_sel_decoder`

## Requirements
- R1: A one-cycle `wait_start` pulse arms the block (`waiting` = 1 after the next edge) and clears `connected` and `phase_out` to 0.
- R2: A selection qualifies when `bus_sel` = 1, `bus_bsy` = 0 and `bus_id[own_id]` = 1 while armed. It is decided on the (S+2)-th rising edge after the bus first qualifies, with S = `settle_cycles`. If the bus stops qualifying before then, no decision is made and the block keeps waiting.
- R3: With exactly two ID bits set, one being the own bit, the block sets flag bit 0 (selection) and sets `connected`. It sets `phase_out` to 1 (message-out) if `bus_atn` is 1, or to 2 (command-out) if it is 0. Bits 1 and 2 stay clear.
- R4: With only the own ID bit set, flag bit 0 (selection) and flag bit 1 (ID error) are set in the same cycle. `connected` becomes 1 and `phase_out` stays 0 (no automatic phase).
- R5: Flag bit 2 (without ATN) is set only for a single-bit selection with `bus_atn` = 0.
- R6: With three or more ID bits set, only flag bit 1 (ID error) is set, and `connected` stays 0.
- R7: Every decision clears `waiting`. No further selection is decided until the next `wait_start`.
- R8: A bus whose own ID bit is clear, or any bus activity while not armed, sets no flag.
- R9: Flags stay set until a 1 is written to the matching `irq_clr` bit. A flag being set wins over a clear of the same bit in the same cycle.
- R10: During and after reset, `irq_flags`, `waiting`, `connected` and `phase_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_id | input | $clog2(ID_W) | Index of this target's ID bit |
| settle_cycles | input | SETTLE_W | Bus settle delay in clock cycles |
| wait_start | input | 1 | Arms the wait-for-selection command |
| bus_id | input | ID_W | Data-bus ID bits, active high |
| bus_sel | input | 1 | SEL, active high |
| bus_bsy | input | 1 | BSY, active high |
| bus_atn | input | 1 | ATN, active high |
| irq_clr | input | 3 | Write-one-to-clear pulses for the flags |
| irq_flags | output | 3 | Sticky flags: bit 0 selection, bit 1 ID error, bit 2 without ATN |
| waiting | output | 1 | Wait-for-selection command active |
| connected | output | 1 | Connection established |
| phase_out | output | 2 | Automatic next phase: 0 none, 1 message-out, 2 command-out |

## Verification
The hardest case to reach is a selection that qualifies and then falls away inside the settle window. Random stimulus almost never removes SEL at exactly that point. A directed case starts a long settle delay, drops SEL partway through, and checks that no flag appears and the command stays armed. A second hard case is a clear pulse that lands on the decision edge. The bench gets there by counting the S+1 edges itself and driving `irq_clr` only for the decision cycle. Random trials cover own IDs, bit counts, ATN levels and settle delays.

// File: rtl/scsi_sel_decoder.sv
module scsi_sel_decoder #(
  parameter int ID_W     = 8,
  parameter int SETTLE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(ID_W)-1:0] own_id,
  input  logic [SETTLE_W-1:0]     settle_cycles,
  input  logic                    wait_start,
  input  logic [ID_W-1:0]         bus_id,
  input  logic                    bus_sel,
  input  logic                    bus_bsy,
  input  logic                    bus_atn,
  input  logic [2:0]              irq_clr,
  output logic [2:0]              irq_flags,
  output logic                    waiting,
  output logic                    connected,
  output logic [1:0]              phase_out
);
  localparam int CNT_W = $clog2(ID_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SETTLE} state_t;

  state_t              st;
  logic [SETTLE_W-1:0] cnt;
  logic [CNT_W-1:0]    n_ids;
  logic                hit, decide, one_id, two_id, many_id;
  logic [2:0]          set_v;

  always_comb begin
    n_ids = '0;
    for (int i = 0; i < ID_W; i++) n_ids = n_ids + CNT_W'(bus_id[i]);
  end

  assign hit     = bus_sel & ~bus_bsy & bus_id[own_id];
  assign decide  = (st == ST_SETTLE) && hit && (cnt == '0);
  assign one_id  = (n_ids == CNT_W'(1));
  assign two_id  = (n_ids == CNT_W'(2));
  assign many_id = (n_ids >= CNT_W'(3));

  assign set_v[0] = decide & (one_id | two_id);
  assign set_v[1] = decide & (one_id | many_id);
  assign set_v[2] = decide & one_id & ~bus_atn;

  assign waiting = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (wait_start) begin
      st  <= ST_WAIT;
      cnt <= '0;
    end else begin
      case (st)
        ST_WAIT: if (hit) begin
          st  <= ST_SETTLE;
          cnt <= settle_cycles;
        end
        ST_SETTLE: begin
          if (!hit)             st <= ST_WAIT;
          else if (cnt == '0)   st <= ST_IDLE;
          else                  cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~irq_clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      connected <= 1'b0;
      phase_out <= 2'd0;
    end else if (wait_start) begin
      connected <= 1'b0;
      phase_out <= 2'd0;
    end else if (decide) begin
      connected <= one_id | two_id;
      if (two_id) phase_out <= bus_atn ? 2'd1 : 2'd2;
    end
  end
endmodule

// File: rtl/scsi_sel_decoder_chk.sv
module scsi_sel_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wait_start,
  input logic [2:0] irq_clr,
  input logic [2:0] irq_flags,
  input logic       waiting,
  input logic       connected,
  input logic [1:0] phase_out
);
  // R4: connection with no automatic phase only arises from a single-ID selection
  a_r4_single_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(connected) && phase_out == 2'd0) |-> (irq_flags[0] && irq_flags[1]));

  // R6: command ended without connecting means an ID error
  a_r6_invalid_iderr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(waiting) && !connected) |-> irq_flags[1]);

  a_r7_connect_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    connected |-> !waiting);

  a_r3_phase_needs_connect: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_out != 2'd0) |-> connected);

  a_r8_flags_need_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_flags[0]) || $rose(irq_flags[1])) |-> $past(waiting));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (~irq_flags & $past(irq_flags) & ~$past(irq_clr)) == 3'b000);

  a_r1_connect_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |=> (!connected && phase_out == 2'd0 && waiting));
endmodule

bind scsi_sel_decoder scsi_sel_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wait_start(wait_start), .irq_clr(irq_clr),
  .irq_flags(irq_flags), .waiting(waiting), .connected(connected),
  .phase_out(phase_out)
);

// File: tb/scsi_sel_decoder_tb_top.sv
`timescale 1ns/1ps
module scsi_sel_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] own_id = '0;
  logic [3:0] settle_cycles = '0;
  logic       wait_start = 1'b0;
  logic [7:0] bus_id = '0;
  logic       bus_sel = 1'b0, bus_bsy = 1'b0, bus_atn = 1'b0;
  logic [2:0] irq_clr = '0;
  logic [2:0] irq_flags;
  logic       waiting, connected;
  logic [1:0] phase_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scsi_sel_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .settle_cycles(settle_cycles),
    .wait_start(wait_start), .bus_id(bus_id), .bus_sel(bus_sel), .bus_bsy(bus_bsy),
    .bus_atn(bus_atn), .irq_clr(irq_clr), .irq_flags(irq_flags), .waiting(waiting),
    .connected(connected), .phase_out(phase_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int nbits(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  function automatic logic [2:0] exp_flags(input logic [7:0] id, input logic [2:0] own, input logic atn);
    int c = nbits(id);
    if (!id[own]) return 3'b000;
    if (c == 1) return {~atn, 2'b11};
    if (c == 2) return 3'b001;
    return 3'b010;
  endfunction

  function automatic logic [1:0] exp_phase(input logic [7:0] id, input logic [2:0] own, input logic atn);
    if (id[own] && nbits(id) == 2) return atn ? 2'd1 : 2'd2;
    return 2'd0;
  endfunction

  function automatic string req_of(input logic [7:0] id, input logic [2:0] own);
    int c = nbits(id);
    if (!id[own]) return "R8";
    if (c == 1) return "R4";
    if (c == 2) return "R3";
    return "R6";
  endfunction

  task automatic arm(input logic [2:0] own, input logic [3:0] s);
    own_id = own;
    settle_cycles = s;
    wait_start = 1'b1;
    tick(1);
    wait_start = 1'b0;
    check("R1 waiting", waiting, 1'b1);
    check("R1 connected", connected, 1'b0);
  endtask

  task automatic clear_all();
    bus_sel = 1'b0;
    irq_clr = 3'b111;
    tick(1);
    irq_clr = 3'b000;
    check("R9 clear", irq_flags, 3'b000);
  endtask

  task automatic run_sel(input logic [2:0] own, input logic [7:0] id, input logic atn, input logic [3:0] s);
    logic [2:0] ef;
    logic own_hit;
    string r;
    ef = exp_flags(id, own, atn);
    own_hit = id[own];
    r = req_of(id, own);
    arm(own, s);
    bus_id = id; bus_atn = atn; bus_bsy = 1'b0; bus_sel = 1'b1;
    tick(int'(s) + 1);
    check("R2 early", irq_flags, 3'b000);
    tick(1);
    check({r, " flags"}, irq_flags, ef);
    check({r, " phase"}, phase_out, exp_phase(id, own, atn));
    check({r, " connected"}, connected, (ef[0] === 1'b1));
    check("R7 waiting", waiting, !own_hit);
    if (ef[2]) check("R5 noatn", irq_flags[2], 1'b1);
    clear_all();
  endtask

  function automatic logic [7:0] make_id(input logic [2:0] own, input int k);
    logic [7:0] v;
    if (k == 0) begin
      v = 8'($urandom);
      v[own] = 1'b0;
      return v;
    end
    v = 8'b1 << own;
    while (nbits(v) < k) v[$urandom_range(7, 0)] = 1'b1;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    check("R10 flags", irq_flags, 3'b000);
    check("R10 waiting", waiting, 1'b0);
    check("R10 connected", connected, 1'b0);
    check("R10 phase", phase_out, 2'd0);
    rst_n = 1'b1;
    tick(1);

    // directed corners
    run_sel(3'd5, 8'b0010_0000, 1'b0, 4'd0);   // R4 + R5 without ATN
    run_sel(3'd5, 8'b0010_0000, 1'b1, 4'd3);   // R4 with ATN: no bit 2
    run_sel(3'd0, 8'b1000_0001, 1'b1, 4'd2);   // R3 message-out
    run_sel(3'd0, 8'b1000_0001, 1'b0, 4'd15);  // R3 command-out, long settle
    run_sel(3'd7, 8'b1110_0000, 1'b0, 4'd1);   // R6
    run_sel(3'd2, 8'b1111_1011, 1'b1, 4'd0);   // R8 no own bit

    // R2: selection withdrawn during settle window
    arm(3'd4, 4'd6);
    bus_id = 8'b0001_0001; bus_atn = 1'b1; bus_sel = 1'b1;
    tick(3);
    bus_sel = 1'b0;
    tick(12);
    check("R2 withdrawn flags", irq_flags, 3'b000);
    check("R2 withdrawn waiting", waiting, 1'b1);
    // BSY already high: no qualification
    bus_sel = 1'b1; bus_bsy = 1'b1;
    tick(12);
    check("R2 bsy flags", irq_flags, 3'b000);
    bus_bsy = 1'b0; bus_sel = 1'b0;

    // R9: clear on the decision edge loses to the set
    arm(3'd1, 4'd2);
    bus_id = 8'b0000_0010; bus_atn = 1'b0; bus_sel = 1'b1;
    tick(3);
    irq_clr = 3'b111;
    tick(1);
    irq_clr = 3'b000;
    check("R9 set wins", irq_flags, 3'b111);
    bus_sel = 1'b0;
    tick(4);
    check("R9 sticky", irq_flags, 3'b111);
    irq_clr = 3'b010;
    tick(1);
    irq_clr = 3'b000;
    check("R9 per bit", irq_flags, 3'b101);
    clear_all();

    // R7/R8: not armed after a decision, new selection ignored
    bus_id = 8'b0000_0110; bus_sel = 1'b1;
    tick(20);
    check("R7 unarmed flags", irq_flags, 3'b000);
    check("R7 unarmed connected", connected, 1'b1);
    bus_sel = 1'b0;

    // random trials
    for (int t = 0; t < 250; t++) begin
      logic [2:0] own;
      int k;
      own = 3'($urandom_range(7, 0));
      k = $urandom_range(4, 0);
      if (k == 4) k = $urandom_range(8, 3);
      run_sel(own, make_id(own, k), 1'($urandom), 4'($urandom_range(5, 0)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule